// File: doc/BRIEF.md
# Power-Up Configuration Source Selector

This block decides what a configuration register file holds once the main supply becomes valid. When `supplyValid` rises, the selector samples three inputs: the level of the programming pin, a retain flag that only the host can set, and three redundant fuse-load bits. It then picks one of four outcomes. It can copy a built-in default image, copy the fuse image one register per clock, keep the present contents untouched, or leave the file cleared. Every outcome except the keep outcome first clears the whole file to zero.

The register file sits inside the block. Every write into it is mirrored on a write port (`cfgWrEn`, `cfgWrAddr`, `cfgWrData`) so downstream shadow copies can follow. The host can read and write registers whenever no sequence is clearing or loading. A lock bit stored in the file stops all later host writes until a new load sequence replaces the contents. At the end of a sequence `seqDone` goes high and `srcStatus` reports which outcome was taken.

Top module: `cfg_source_sel`

## Requirements
- R1: Power-on reset zeroes every register and the retain flag. On any outcome other than keep, all NUM_REGS registers are written with zero, in ascending address order, before any register is loaded.
- R2: If `progPinHigh` is 1 when the sequence decides, register i is loaded with (ROM_BASE + i*ROM_STEP) mod 2^DATA_W, whatever the retain flag and fuse bits are. `srcStatus` then reads 1.
- R3: If `progPinHigh` is 0 and the retain flag is 1, no register is written, the contents stay as they were, and `srcStatus` reads 3.
- R4: If `progPinHigh` is 0, the retain flag is 0 and all three `fuseLoadBits` are 1, register i is loaded with the `fuseRdData` value presented while `fuseRdAddr` equals i. `srcStatus` then reads 2.
- R5: The fuse-load condition is the AND of the three fuse-load bits. If `progPinHigh` is 0, the retain flag is 0 and any fuse-load bit is 0, all registers stay zero and `srcStatus` reads 0.
- R6: The retain flag is 0 after reset. It changes only when a `hostRetainWr` pulse is accepted, taking the value of `hostRetainVal`.
- R7: When bit DATA_W-1 of register NUM_REGS-1 is 1, `cfgLocked` is 1. Host register writes and retain-flag writes are then ignored. A later load sequence still rewrites the file.
- R8: Host writes arriving while the sequence is clearing or loading are ignored. At other times an unlocked host write to an in-range address takes effect at the next clock. `hostRdData` shows the register at `hostRdAddr` in the same cycle.
- R9: A sequence starts on a rising `supplyValid` while idle or done. `seqDone` is 0 from the decide cycle until the sequence ends, and then stays 1 with `srcStatus` valid.
- R10: `cfgWrEn` is high exactly for the cycles in which the file is written. A default or fuse outcome therefore gives 2*NUM_REGS write cycles, a zero outcome gives NUM_REGS, and a keep outcome gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| supplyValid | input | 1 | Main supply valid; its rising edge starts a sequence |
| progPinHigh | input | 1 | Programming pin is tied to the core logic rail |
| fuseLoadBits | input | 3 | Redundant fuse-load bits |
| fuseRdAddr | output | $clog2(NUM_REGS) | Fuse image read address |
| fuseRdData | input | DATA_W | Fuse image data for `fuseRdAddr` |
| hostWrEn | input | 1 | Host register write strobe |
| hostWrAddr | input | $clog2(NUM_REGS) | Host write address |
| hostWrData | input | DATA_W | Host write data |
| hostRetainWr | input | 1 | Host write strobe for the retain flag |
| hostRetainVal | input | 1 | Value written to the retain flag |
| hostRdAddr | input | $clog2(NUM_REGS) | Host read address |
| hostRdData | output | DATA_W | Register contents at `hostRdAddr` |
| cfgWrEn | output | 1 | Register file write strobe |
| cfgWrAddr | output | $clog2(NUM_REGS) | Register file write address |
| cfgWrData | output | DATA_W | Register file write data |
| seqDone | output | 1 | Sequence finished |
| srcStatus | output | 2 | Outcome: 0 zero, 1 default, 2 fuse, 3 kept |
| cfgLocked | output | 1 | Lock bit currently set |

## Verification
The bench builds the block with NUM_REGS=6, DATA_W=8, ROM_BASE=165 and ROM_STEP=29. With only six registers, each clear and load pass is short, so many outcomes fit in one run. The lock register is easy to reach with random host writes and with random fuse images whose top bit is set. With these values the default image leaves the lock clear, so locking and unlocking through later sequences both occur. The short clear window also allows a host write to be placed after the clear has passed address 0, where an accepted write would survive and be visible.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_CLEAR,
    ST_LOAD,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_FUSE = 2'd2,
    SRC_KEEP = 2'd3
  } loadSrc_t;

  typedef struct packed {
    logic clrWr;
    logic romWr;
    logic fuseWr;
    logic busy;
  } seqStrobe_t;

endpackage

// File: rtl/cfgsel_ctrl.sv
module cfgsel_ctrl
  import cfgsel_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supplyValid,
  input  logic             progPinHigh,
  input  logic [2:0]       fuseLoadBits,
  input  logic             retainFlag,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output loadSrc_t         loadSrc,
  output logic             seqDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seqState_t state;
  logic      supplyPrev;
  logic      supplyRise;
  logic      fuseAll;

  assign supplyRise = supplyValid && !supplyPrev;
  assign fuseAll    = &fuseLoadBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      supplyPrev <= 1'b0;
      idx        <= '0;
      loadSrc    <= SRC_ZERO;
    end else begin
      supplyPrev <= supplyValid;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (supplyRise) state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          idx <= '0;
          if (progPinHigh) begin
            loadSrc <= SRC_ROM;
            state   <= ST_CLEAR;
          end else if (retainFlag) begin
            loadSrc <= SRC_KEEP;
            state   <= ST_DONE;
          end else if (fuseAll) begin
            loadSrc <= SRC_FUSE;
            state   <= ST_CLEAR;
          end else begin
            loadSrc <= SRC_ZERO;
            state   <= ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          if (idx == LAST_IDX) begin
            idx   <= '0;
            state <= (loadSrc == SRC_ZERO) ? ST_DONE : ST_LOAD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_LOAD: begin
          if (idx == LAST_IDX) begin
            idx   <= '0;
            state <= ST_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clrWr  = (state == ST_CLEAR);
    strobe.romWr  = (state == ST_LOAD) && (loadSrc == SRC_ROM);
    strobe.fuseWr = (state == ST_LOAD) && (loadSrc == SRC_FUSE);
    strobe.busy   = (state == ST_CLEAR) || (state == ST_LOAD);
  end

  assign seqDone = (state == ST_DONE);

  // R2: pin level overrides both flags
  p_rom_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && progPinHigh) |=> loadSrc == SRC_ROM);

  // R5: fuse outcome needs all three load bits
  p_fuse_needs_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && !fuseAll) |=> loadSrc != SRC_FUSE);

  // R3: skipping the clear pass happens only on the keep outcome
  p_keep_skips_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state) == ST_DECIDE) |-> loadSrc == SRC_KEEP);

  // R1: a load pass is always entered from a clear pass
  p_load_after_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) != ST_LOAD) |-> $past(state) == ST_CLEAR);

  // R9: done drops as soon as a new sequence begins
  p_done_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy |-> !seqDone);

endmodule

// File: rtl/cfgsel_datapath.sv
module cfgsel_datapath
  import cfgsel_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int ROM_BASE = 165,
  parameter int ROM_STEP = 29,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] fuseRdData,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRetainWr,
  input  logic              hostRetainVal,
  input  logic [IDX_W-1:0]  hostRdAddr,
  output logic [DATA_W-1:0] hostRdData,
  output logic              retainFlag,
  output logic              cfgLocked,
  output logic              cfgWrEn,
  output logic [IDX_W-1:0]  cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData
);

  localparam int LOCK_REG = NUM_REGS - 1;
  localparam int LOCK_BIT = DATA_W - 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] cfgRegs;
  logic [NUM_REGS-1:0][DATA_W-1:0] romImage;
  logic hostAccept;
  logic hostOpen;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rom
    assign romImage[g] = DATA_W'(ROM_BASE + g * ROM_STEP);
  end

  assign cfgLocked  = cfgRegs[LOCK_REG][LOCK_BIT];
  assign hostOpen   = !strobe.busy && !cfgLocked;
  assign hostAccept = hostWrEn && hostOpen && (int'(hostWrAddr) < NUM_REGS);

  always_comb begin
    cfgWrEn   = strobe.clrWr || strobe.romWr || strobe.fuseWr || hostAccept;
    cfgWrAddr = strobe.busy ? idx : hostWrAddr;
    if (strobe.clrWr)       cfgWrData = '0;
    else if (strobe.romWr)  cfgWrData = romImage[idx];
    else if (strobe.fuseWr) cfgWrData = fuseRdData;
    else                    cfgWrData = hostWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgRegs <= '0;
    end else if (cfgWrEn) begin
      cfgRegs[cfgWrAddr] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retainFlag <= 1'b0;
    end else if (hostRetainWr && hostOpen) begin
      retainFlag <= hostRetainVal;
    end
  end

  assign hostRdData = (int'(hostRdAddr) < NUM_REGS) ? cfgRegs[hostRdAddr] : '0;

  // checker-side capture of the previous clear write
  logic             clrSeenQ;
  logic [IDX_W-1:0] clrIdxQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clrSeenQ <= 1'b0;
      clrIdxQ  <= '0;
    end else begin
      clrSeenQ <= strobe.clrWr;
      clrIdxQ  <= idx;
    end
  end

  // R1: each clear cycle leaves a zero in the addressed register
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clrSeenQ |-> cfgRegs[clrIdxQ] == '0);

  // R7: a locked, idle file does not change
  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgLocked && !strobe.busy) |=> $stable(cfgRegs));

  // R6: retain flag rises only after a host retain write
  p_retain_host_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retainFlag) |-> $past(hostRetainWr));

  // R10: a busy cycle always writes the file at the sequence index
  p_busy_writes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy |-> (cfgWrEn && cfgWrAddr == idx));

endmodule

// File: rtl/cfg_source_sel.sv
module cfg_source_sel
  import cfgsel_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  parameter int ROM_BASE = 165,
  parameter int ROM_STEP = 29,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supplyValid,
  input  logic              progPinHigh,
  input  logic [2:0]        fuseLoadBits,
  output logic [IDX_W-1:0]  fuseRdAddr,
  input  logic [DATA_W-1:0] fuseRdData,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRetainWr,
  input  logic              hostRetainVal,
  input  logic [IDX_W-1:0]  hostRdAddr,
  output logic [DATA_W-1:0] hostRdData,
  output logic              cfgWrEn,
  output logic [IDX_W-1:0]  cfgWrAddr,
  output logic [DATA_W-1:0] cfgWrData,
  output logic              seqDone,
  output logic [1:0]        srcStatus,
  output logic              cfgLocked
);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] seqIdx;
  loadSrc_t         loadSrc;
  logic             retainFlag;

  cfgsel_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .supplyValid  (supplyValid),
    .progPinHigh  (progPinHigh),
    .fuseLoadBits (fuseLoadBits),
    .retainFlag   (retainFlag),
    .strobe       (strobe),
    .idx          (seqIdx),
    .loadSrc      (loadSrc),
    .seqDone      (seqDone)
  );

  cfgsel_datapath #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ROM_BASE (ROM_BASE),
    .ROM_STEP (ROM_STEP)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .idx           (seqIdx),
    .fuseRdData    (fuseRdData),
    .hostWrEn      (hostWrEn),
    .hostWrAddr    (hostWrAddr),
    .hostWrData    (hostWrData),
    .hostRetainWr  (hostRetainWr),
    .hostRetainVal (hostRetainVal),
    .hostRdAddr    (hostRdAddr),
    .hostRdData    (hostRdData),
    .retainFlag    (retainFlag),
    .cfgLocked     (cfgLocked),
    .cfgWrEn       (cfgWrEn),
    .cfgWrAddr     (cfgWrAddr),
    .cfgWrData     (cfgWrData)
  );

  assign fuseRdAddr = seqIdx;
  assign srcStatus  = loadSrc;

endmodule

// File: tb/tb_cfg_source_sel.sv
module tb_cfg_source_sel;

  localparam int N     = 6;
  localparam int W     = 8;
  localparam int RBASE = 165;
  localparam int RSTEP = 29;
  localparam int AW    = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supplyValid = 1'b0, progPinHigh = 1'b0;
  logic [2:0] fuseLoadBits = '0;
  logic [AW-1:0] fuseRdAddr;
  logic [W-1:0] fuseRdData;
  logic hostWrEn = 1'b0;
  logic [AW-1:0] hostWrAddr = '0;
  logic [W-1:0] hostWrData = '0;
  logic hostRetainWr = 1'b0, hostRetainVal = 1'b0;
  logic [AW-1:0] hostRdAddr = '0;
  logic [W-1:0] hostRdData;
  logic cfgWrEn;
  logic [AW-1:0] cfgWrAddr;
  logic [W-1:0] cfgWrData;
  logic seqDone, cfgLocked;
  logic [1:0] srcStatus;

  logic [W-1:0] fuseMask = 8'h3C;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] model [N];
  logic retainM = 1'b0;

  always #5 clk = ~clk;

  assign fuseRdData = fuseMask ^ W'(int'(fuseRdAddr) * 59);

  cfg_source_sel #(.NUM_REGS(N), .DATA_W(W), .ROM_BASE(RBASE), .ROM_STEP(RSTEP)) dut (
    .clk(clk), .rst_n(rst_n), .supplyValid(supplyValid), .progPinHigh(progPinHigh),
    .fuseLoadBits(fuseLoadBits), .fuseRdAddr(fuseRdAddr), .fuseRdData(fuseRdData),
    .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr), .hostWrData(hostWrData),
    .hostRetainWr(hostRetainWr), .hostRetainVal(hostRetainVal),
    .hostRdAddr(hostRdAddr), .hostRdData(hostRdData),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrData(cfgWrData),
    .seqDone(seqDone), .srcStatus(srcStatus), .cfgLocked(cfgLocked)
  );

  function automatic logic [W-1:0] romVal(int i);
    return W'(RBASE + i * RSTEP);
  endfunction

  function automatic logic [W-1:0] fuseVal(int i);
    return fuseMask ^ W'(i * 59);
  endfunction

  function automatic logic modelLocked();
    return model[N-1][W-1];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < N; i++) begin
      hostRdAddr = AW'(i);
      #1;
      chk(hostRdData == model[i], req, hostRdData, model[i]);
    end
    chk(cfgLocked == modelLocked(), "R7 lock flag", cfgLocked, modelLocked());
  endtask

  task automatic hostWrite(input int a, input logic [W-1:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrAddr = AW'(a); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (!modelLocked()) model[a] = d;
  endtask

  task automatic setRetain(input logic v);
    @(negedge clk);
    hostRetainWr = 1'b1; hostRetainVal = v;
    @(negedge clk);
    hostRetainWr = 1'b0;
    if (!modelLocked()) retainM = v;
  endtask

  // Run one sequence; optionally inject a host write to address 0 mid-clear.
  task automatic runSeq(input logic pin, input logic [2:0] bits, input logic inject);
    int wrCount = 0;
    int expSrc;
    int expWr;
    int waitCnt = 0;
    @(negedge clk);
    supplyValid = 1'b0; progPinHigh = pin; fuseLoadBits = bits;
    @(negedge clk);
    supplyValid = 1'b1;
    if (pin) begin expSrc = 1; expWr = 2 * N; for (int i = 0; i < N; i++) model[i] = romVal(i); end
    else if (retainM) begin expSrc = 3; expWr = 0; end
    else if (&bits) begin expSrc = 2; expWr = 2 * N; for (int i = 0; i < N; i++) model[i] = fuseVal(i); end
    else begin expSrc = 0; expWr = N; for (int i = 0; i < N; i++) model[i] = '0; end
    @(negedge clk);
    chk(seqDone == 1'b0, "R9 done low at decide", seqDone, 0);
    while (!seqDone && waitCnt < 100) begin
      if (cfgWrEn) wrCount++;
      if (inject && waitCnt == 2) begin hostWrEn = 1'b1; hostWrAddr = '0; hostWrData = 8'h77; end
      else hostWrEn = 1'b0;
      @(negedge clk);
      waitCnt++;
    end
    hostWrEn = 1'b0;
    chk(seqDone == 1'b1, "R9 sequence finished", seqDone, 1);
    chk(int'(srcStatus) == expSrc, "R2/R3/R4/R5 status", srcStatus, expSrc);
    chk(wrCount == expWr, "R10 write cycles", wrCount, expWr);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(seqDone == 1'b0, "R1 reset done", seqDone, 0);
    chk(srcStatus == 2'd0, "R1 reset status", srcStatus, 0);
    checkAll("R1 reset contents");

    // R2 default image regardless of flags
    runSeq(1'b1, 3'b111, 1'b0);
    checkAll("R2 default image");

    // R8 host write accepted when idle
    hostWrite(2, 8'h4B);
    checkAll("R8 host write");

    // R5 one fuse bit clear -> zero outcome
    runSeq(1'b0, 3'b110, 1'b0);
    checkAll("R5 partial fuse bits");

    // R4 fuse image
    fuseMask = 8'h19;
    runSeq(1'b0, 3'b111, 1'b0);
    checkAll("R4 fuse image");

    // R3 retain keeps contents, even after host edit
    hostWrite(0, 8'h21);
    setRetain(1'b1);
    runSeq(1'b0, 3'b111, 1'b0);
    checkAll("R3 keep contents");
    // R2 pin overrides retain
    runSeq(1'b1, 3'b000, 1'b0);
    checkAll("R2 pin over retain");
    setRetain(1'b0);

    // R8 host write during clear is ignored (zero outcome)
    runSeq(1'b0, 3'b011, 1'b1);
    checkAll("R8 write during clear ignored");

    // R7 lock blocks host and retain writes
    hostWrite(N - 1, 8'h80);
    chk(cfgLocked == 1'b1, "R7 lock set", cfgLocked, 1);
    hostWrite(1, 8'h5D);
    setRetain(1'b1);
    checkAll("R7 locked write ignored");
    // R6 retain write ignored while locked -> zero outcome, not keep
    runSeq(1'b0, 3'b000, 1'b0);
    checkAll("R6 retain unchanged under lock");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int nw;
      fuseMask = W'($urandom);
      if ($urandom_range(0, 2) == 0) setRetain(1'($urandom));
      nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++) hostWrite($urandom_range(0, N - 1), W'($urandom));
      runSeq($urandom_range(0, 3) == 0, ($urandom_range(0, 1) == 0) ? 3'b111 : 3'($urandom),
             1'b0);
      checkAll("R2/R3/R4/R5 random outcome");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule